// File: doc/BRIEF.md
# Sub-Radix SAR Channel Reconstruction with Background LMS Trim

This block is the digital back end of a single successive-approximation converter channel whose capacitor array steps by a ratio below two. For each conversion it takes the twelve raw comparator decisions and forms the output word. Each decision is read as +1 or -1 and multiplied by its own weight coefficient. The signed sum of these terms is added to a digital offset term.

The weights start from a radix-1.85 ladder. They are then trimmed continuously while normal conversions run, and the offset is trimmed with them. When a reference value for the most recent conversion arrives, the block forms the error as the reference minus the reconstructed word. It scales that error by a right shift picked from a 4-bit control. It then steps every coefficient by a least-mean-square rule and saturates each one at the edge of its fixed-point range. This removes the channel's gain error, offset and static nonlinearity without a dedicated calibration interval. A single enable freezes the coefficients. While it is low, conversions continue using the held values.

Top module: `wbr_lms_channel`

## Requirements
- R1: One cycle after `raw_valid` is sampled high, `out_valid` pulses high for one cycle. `out_data` then equals the offset plus, for every bit index i from 0 to 11, +w_i if `raw_bits[i]` is 1 and -w_i if it is 0. The value is taken with the coefficients in force at the `raw_valid` edge. `out_data` holds its value when no conversion arrives.
- R2: After synchronous reset, `out_valid` and `out_data` are 0. The offset is 0. The MSB weight w_11 is 16000, which is 250.0 in the signed 16-bit format with 6 fractional bits. Each lower weight is w_(i-1) = floor((w_i*100+92)/185).
- R3: On a reference strobe the error is `ref_data` minus the most recent `out_data`. The step is that error arithmetically shifted right by `mu_shift`, which rounds toward minus infinity.
- R4: When `ref_valid` and `adapt_en` are both high and a conversion is pending, each weight w_i gains the step if bit i of that conversion was 1 and loses it if the bit was 0. The offset gains the step.
- R5: While `adapt_en` is low, a reference strobe changes no coefficient, and reconstruction keeps using the held coefficients.
- R6: Every reference strobe consumes the pending conversion. A strobe that arrives with no conversion since the previous strobe changes no coefficient.
- R7: Every weight and the offset saturate at -32768 and 32767 and never wrap.
- R8: When `raw_valid` and `ref_valid` are high in the same cycle, the update uses the earlier conversion. The new output is formed with the coefficients from before that update, and the new conversion becomes the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw decision word valid |
| raw_bits | input | 12 | Comparator decisions, bit 11 is the MSB |
| ref_valid | input | 1 | Reference sample valid |
| ref_data | input | 20 | Signed reference for the last conversion, 6 fractional bits |
| adapt_en | input | 1 | Coefficient adaptation enable |
| mu_shift | input | 4 | Step size as a right-shift count |
| out_valid | output | 1 | Reconstructed sample valid pulse |
| out_data | output | 20 | Signed reconstructed sample, 6 fractional bits |

## Verification
The bench goes after the sign convention of zero bits. A design that drops the -1 mapping would add nothing for a 0 decision, and the all-zero and mixed patterns would come out wrong. It drives a reference error large enough to saturate every coefficient and then pushes further in the same direction. A design that wraps would show a large negative jump on the next all-ones conversion. The bench also repeats a reference with no new conversion in between, and it issues a reference in the same cycle as a conversion. A design without the pending flag would apply a stale second update. A design that orders the simultaneous case wrongly would output with the updated coefficients or correlate the error with the new bits. Finally, it shifts negative errors to check the floor rounding and strobes with the enable low to check the freeze.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int NB       = 12;
    localparam int WW       = 16;
    localparam int FRAC     = 6;
    localparam int OW       = WW + $clog2(NB + 1);
    localparam int SHW      = 4;
    localparam int MSB_INIT = 16000;
    localparam int RAD_NUM  = 185;
    localparam int RAD_DEN  = 100;
    localparam int WMAX     = (2 ** (WW - 1)) - 1;
    localparam int WMIN     = -(2 ** (WW - 1));

    typedef logic signed [WW-1:0] coef_t;
    typedef logic signed [OW-1:0] samp_t;
    typedef logic signed [OW:0]   err_t;
    typedef logic signed [OW+1:0] wide_t;

    typedef struct packed {
        logic apply;
        err_t step;
    } step_t;

    typedef struct packed {
        logic          vld;
        logic [NB-1:0] bits;
        samp_t         val;
    } conv_t;

    function automatic coef_t init_coef(input int idx);
        int w;
        w = MSB_INIT;
        for (int k = NB - 1; k > idx; k--) begin
            w = (w * RAD_DEN + (RAD_NUM / 2)) / RAD_NUM;
        end
        return coef_t'(w);
    endfunction

    function automatic coef_t sat_step(input coef_t base, input err_t delta, input logic neg);
        wide_t b;
        wide_t d;
        wide_t s;
        b = wide_t'(base);
        d = wide_t'(delta);
        if (neg) d = -d;
        s = b + d;
        if (s > wide_t'(WMAX))      return coef_t'(WMAX);
        else if (s < wide_t'(WMIN)) return coef_t'(WMIN);
        else                        return coef_t'(s);
    endfunction

endpackage

// File: rtl/wbr_coef_cell.sv
module wbr_coef_cell
    import wbr_pkg::*;
#(
    parameter coef_t INIT = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  step_t stp,
    input  logic  neg,
    output coef_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT;
        end else if (stp.apply) begin
            q <= sat_step(q, stp.step, neg);
        end
    end

endmodule

// File: rtl/wbr_recon.sv
module wbr_recon
    import wbr_pkg::*;
(
    input  logic [NB-1:0]     bits,
    input  coef_t [NB-1:0]    w,
    input  coef_t             off,
    output samp_t             sum
);

    always_comb begin
        samp_t acc;
        samp_t term;
        acc = samp_t'(off);
        for (int i = 0; i < NB; i++) begin
            term = samp_t'(w[i]);
            if (bits[i]) acc = acc + term;
            else         acc = acc - term;
        end
        sum = acc;
    end

endmodule

// File: rtl/wbr_err.sv
module wbr_err
    import wbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_valid,
    input  logic [NB-1:0]    raw_bits,
    input  samp_t            recon,
    input  logic             ref_valid,
    input  samp_t            ref_data,
    input  logic             adapt_en,
    input  logic [SHW-1:0]   mu_shift,
    output conv_t            held,
    output logic             pend,
    output step_t            stp
);

    err_t err;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            pend <= 1'b0;
        end else begin
            held.vld <= raw_valid;
            if (raw_valid) begin
                held.bits <= raw_bits;
                held.val  <= recon;
                pend      <= 1'b1;
            end else if (ref_valid) begin
                pend <= 1'b0;
            end
        end
    end

    always_comb begin
        err       = err_t'(ref_data) - err_t'(held.val);
        stp.step  = err >>> mu_shift;
        stp.apply = ref_valid & adapt_en & pend;
    end

endmodule

// File: rtl/wbr_lms_channel.sv
module wbr_lms_channel
    import wbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raw_valid,
    input  logic [NB-1:0]        raw_bits,
    input  logic                 ref_valid,
    input  logic signed [OW-1:0] ref_data,
    input  logic                 adapt_en,
    input  logic [SHW-1:0]       mu_shift,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data
);

    coef_t [NB-1:0] coefs;
    coef_t          offs;
    samp_t          recon;
    conv_t          held;
    logic           pend;
    step_t          stp;

    wbr_recon u_recon (
        .bits (raw_bits),
        .w    (coefs),
        .off  (offs),
        .sum  (recon)
    );

    wbr_err u_err (
        .clk       (clk),
        .rst       (rst),
        .raw_valid (raw_valid),
        .raw_bits  (raw_bits),
        .recon     (recon),
        .ref_valid (ref_valid),
        .ref_data  (ref_data),
        .adapt_en  (adapt_en),
        .mu_shift  (mu_shift),
        .held      (held),
        .pend      (pend),
        .stp       (stp)
    );

    for (genvar gi = 0; gi < NB; gi++) begin : g_w
        wbr_coef_cell #(.INIT(init_coef(gi))) u_w (
            .clk (clk),
            .rst (rst),
            .stp (stp),
            .neg (~held.bits[gi]),
            .q   (coefs[gi])
        );
    end

    wbr_coef_cell #(.INIT('0)) u_off (
        .clk (clk),
        .rst (rst),
        .stp (stp),
        .neg (1'b0),
        .q   (offs)
    );

    assign out_valid = held.vld;
    assign out_data  = held.val;

endmodule

// File: rtl/wbr_lms_chk.sv
module wbr_lms_chk
    import wbr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                raw_valid,
    input logic                ref_valid,
    input logic                adapt_en,
    input logic                out_valid,
    input logic [OW-1:0]       out_data,
    input logic [NB*WW-1:0]    coef_vec,
    input logic [WW-1:0]       off_q
);

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        raw_valid |=> out_valid); // R1

    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> !out_valid); // R1

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> $stable(out_data)); // R1

    AST_FROZEN_COEF: assert property (@(posedge clk) disable iff (rst)
        !adapt_en |=> ($stable(coef_vec) && $stable(off_q))); // R5

    AST_NO_REF_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> ($stable(coef_vec) && $stable(off_q))); // R4

endmodule

bind wbr_lms_channel wbr_lms_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .raw_valid (raw_valid),
    .ref_valid (ref_valid),
    .adapt_en  (adapt_en),
    .out_valid (out_valid),
    .out_data  (out_data),
    .coef_vec  (coefs),
    .off_q     (offs)
);

// File: tb/tb_wbr_lms_channel.sv
`timescale 1ns/1ps
module tb_wbr_lms_channel;

    localparam int NB = 12;
    localparam int OW = 20;
    localparam int NV = 10;

    localparam logic [NB-1:0] V_BITS [NV] = '{12'hFFF, 12'h000, 12'hA5A, 12'h5A5, 12'h800,
                                              12'h001, 12'h7FF, 12'hC3C, 12'h3C3, 12'hF0F};
    localparam int V_DELTA [NV] = '{640, -300, 1000, -77, 5000, 12345, -999, 64, -1, 2047};
    localparam bit V_EN    [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
    localparam int V_MU    [NV] = '{2, 3, 0, 1, 0, 4, 5, 6, 0, 15};

    logic                 clk = 0;
    logic                 rst;
    logic                 raw_valid;
    logic [NB-1:0]        raw_bits;
    logic                 ref_valid;
    logic signed [OW-1:0] ref_data;
    logic                 adapt_en;
    logic [3:0]           mu_shift;
    logic                 out_valid;
    logic signed [OW-1:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int mw [NB];
    int moff;
    int last_out;
    logic [NB-1:0] last_bits;
    bit pend;

    always #2 clk = ~clk;

    wbr_lms_channel dut (
        .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_bits(raw_bits),
        .ref_valid(ref_valid), .ref_data(ref_data), .adapt_en(adapt_en),
        .mu_shift(mu_shift), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int clampw(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_reset();
        mw[NB-1] = 16000;
        for (int i = NB - 1; i > 0; i--) mw[i-1] = (mw[i] * 100 + 92) / 185;
        moff = 0;
        pend = 0;
        last_out = 0;
        last_bits = '0;
    endtask

    function automatic int model_out(input logic [NB-1:0] b);
        int s;
        s = moff;
        for (int i = 0; i < NB; i++) s = b[i] ? s + mw[i] : s - mw[i];
        return s;
    endfunction

    task automatic model_ref(input int refv, input bit en, input int mu);
        int d;
        if (pend && en) begin
            d = (refv - last_out) >>> mu;
            for (int i = 0; i < NB; i++) mw[i] = clampw(last_bits[i] ? mw[i] + d : mw[i] - d);
            moff = clampw(moff + d);
        end
        pend = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_conv(input logic [NB-1:0] b, input string req);
        int e;
        e = model_out(b);
        raw_valid = 1; raw_bits = b;
        @(negedge clk);
        raw_valid = 0;
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_data), e);
        last_out = e; last_bits = b; pend = 1;
    endtask

    task automatic do_ref(input int refv, input bit en, input int mu);
        ref_valid = 1; ref_data = OW'(refv); adapt_en = en; mu_shift = 4'(mu);
        @(negedge clk);
        ref_valid = 0; adapt_en = 1;
        model_ref(refv, en, mu);
    endtask

    task automatic do_reset();
        rst = 1;
        raw_valid = 0; raw_bits = '0; ref_valid = 0; ref_data = '0;
        adapt_en = 1; mu_shift = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int o;
        do_reset();
        // R2: reset state at the ports
        check("R2 reset valid", int'(out_valid), 0);
        check("R2 reset data", int'(out_data), 0);

        // R1 R3 R4 R5: vector walk, each conversion checks the coefficients left by the previous reference
        for (int v = 0; v < NV; v++) begin
            do_conv(V_BITS[v], "R1 R3 R4 R5 vector");
            do_ref(last_out + V_DELTA[v], V_EN[v], V_MU[v]);
        end
        do_conv(12'h6B1, "R4 after walk");
        // R1: valid is a single pulse and data holds
        o = last_out;
        @(negedge clk);
        check("R1 pulse end", int'(out_valid), 0);
        check("R1 hold", int'(out_data), o);

        // R6: second reference without a new conversion has no effect
        do_ref(last_out + 3000, 1, 0);
        do_ref(last_out + 20000, 1, 0);
        do_conv(12'h9C6, "R6 stale reference");

        // R5: frozen while enable low, even with a pending conversion
        do_ref(last_out - 8000, 0, 0);
        do_conv(12'h9C6, "R5 frozen");

        // R8: simultaneous conversion and reference
        begin
            int e_new;
            e_new = model_out(12'h35A);
            raw_valid = 1; raw_bits = 12'h35A;
            ref_valid = 1; ref_data = OW'(last_out + 4321); adapt_en = 1; mu_shift = 4'd1;
            @(negedge clk);
            raw_valid = 0; ref_valid = 0;
            check("R8 same-cycle out", int'(out_data), e_new);
            model_ref(last_out + 4321, 1, 1);
            last_out = e_new; last_bits = 12'h35A; pend = 1;
        end
        do_conv(12'hE07, "R8 update used earlier bits");

        // R7: saturation with a huge error, then pushed further
        do_conv(12'hFFF, "R7 pre");
        do_ref(last_out + 400000, 1, 0);
        do_conv(12'hFFF, "R7 saturated high");
        do_ref(last_out + 90000, 1, 0);
        do_conv(12'hFFF, "R7 no wrap");
        do_conv(12'h000, "R7 zero bits");

        // R2: mid-run reset restores the radix ladder
        do_reset();
        do_conv(12'h555, "R2 ladder after reset");
        do_conv(12'h000, "R2 all zero");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule